// File: doc/BRIEF.md
# Power-Pulsing Domain and Clock Sequencer

This block switches the supplies of a low-duty-cycle front-end chip. The chip spends most of each cycle asleep. It wakes the analog and threshold-DAC domains for an acquisition window, then the conversion and digital domains while its samples are digitised, and then sleeps again. It stays asleep until a readout token reaches it in the daisy chain. That token is the chip's digital power-on request: it brings back the digital domain and both gated clocks for the readout. When the readout is done, the chip signals the next chip in the chain and powers down again.

Beside the four domain enables, the block gates a fast clock and a slow clock derived from it. It also drives the bias of the two clock receivers, which stays on only in the conversion and readout phases. The trigger-path receivers are biased whenever the analog domain is on. Configuration bits can force any domain on or off regardless of phase. A ready flag for each domain tells downstream logic when a freshly enabled domain has had time to settle.

Top module: `pp_sequencer`

## Requirements
- R1: While reset is held and after it is released, every domain enable, ready flag, receiver bias, end-of-readout pulse and gated clock is low.
- R2: The phase advances only on the event that belongs to the current phase: acq_start from idle to acquire, acq_stop from acquire to convert, conv_end from convert to wait, ro_start from wait to readout, ro_done from readout to idle. An event arriving in any other phase leaves the outputs unchanged.
- R3: pwr_en bit 0 is analog, bit 1 is conversion, bit 2 is DAC and bit 3 is digital. Acquire enables analog and DAC. Convert enables conversion and digital. Readout enables digital only. Idle and wait enable nothing. Each enable follows one clock after the edge that captured the event.
- R4: A set bit in cfg_force_off holds that domain off, and a set bit in cfg_force_on holds it on. Off wins when both are set. Either takes effect one clock after it is applied, and the bit positions match pwr_en.
- R5: Both clock receiver biases are high exactly in the convert and readout phases, whatever the force bits say.
- R6: The trigger receiver bias equals the analog domain enable, forced or sequenced.
- R7: A domain's ready flag rises SETTLE_CYC clocks after its enable rises. It falls in the same cycle as the enable.
- R8: ro_end is a one-clock pulse on the edge that captures ro_done in readout. The digital enable and the clock bias are low one clock later unless digital is forced on.
- R9: gclk_fast reproduces clk and gclk_slow reproduces clk divided by SLOW_DIV while the clock bias is on. Both stay low otherwise. A gate enable changes only while its source clock is low, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast received clock, block clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_start | input | 1 | Start of acquisition window (pulse) |
| acq_stop | input | 1 | End of acquisition, start of conversion (pulse) |
| conv_end | input | 1 | End of conversion (pulse) |
| ro_start | input | 1 | Readout token arriving for this chip (pulse) |
| ro_done | input | 1 | This chip's readout finished (pulse) |
| cfg_force_on | input | 4 | Per-domain force-on bits |
| cfg_force_off | input | 4 | Per-domain force-off bits, dominant |
| pwr_en | output | 4 | Domain enables: analog, conversion, DAC, digital |
| pwr_rdy | output | 4 | Per-domain settled flags |
| gclk_fast | output | 1 | Gated fast clock |
| gclk_slow | output | 1 | Gated divided clock |
| rx_fast_bias | output | 1 | Bias enable of the fast clock receiver |
| rx_slow_bias | output | 1 | Bias enable of the slow clock receiver |
| rx_trig_bias | output | 1 | Bias enable of the trigger-path receivers |
| ro_end | output | 1 | End-of-readout pulse to the next chip |

## Verification
An event captured at an edge moves the phase on that edge. The domain enables, the clock biases and the trigger bias follow at the next edge. The gate enables follow at the falling edge after that. Each table vector therefore drives inputs at a falling edge, removes the event one falling edge later, and samples two falling edges after that, once every result has settled. The ro_end pulse is sampled at the first falling edge after capture and checked gone at the second. The ready flag is sampled one clock before and exactly at clock 1+SETTLE_CYC after the force is applied. The gated clocks are checked by counting rising edges between two falling edges of clk across a fixed 64-cycle window.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int N_DOM   = 4;
  localparam int DOM_ANA = 0;
  localparam int DOM_CNV = 1;
  localparam int DOM_DAC = 2;
  localparam int DOM_DIG = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ACQ  = 3'd1,
    PH_CONV = 3'd2,
    PH_WAIT = 3'd3,
    PH_READ = 3'd4
  } phase_t;
endpackage

// File: rtl/pp_phase_fsm.sv
module pp_phase_fsm
  import pp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acq_start,
  input  logic             acq_stop,
  input  logic             conv_end,
  input  logic             ro_start,
  input  logic             ro_done,
  output logic [N_DOM-1:0] seq_req,
  output logic             clk_req,
  output logic             ro_end
);
  phase_t ph, ph_nx;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_IDLE: if (acq_start) ph_nx = PH_ACQ;
      PH_ACQ:  if (acq_stop)  ph_nx = PH_CONV;
      PH_CONV: if (conv_end)  ph_nx = PH_WAIT;
      PH_WAIT: if (ro_start)  ph_nx = PH_READ;
      PH_READ: if (ro_done)   ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      ro_end <= 1'b0;
    end else begin
      ph     <= ph_nx;
      ro_end <= (ph == PH_READ) && ro_done;
    end
  end

  // Domain requests per phase; the digital request in readout is the token wake-up
  always_comb begin
    seq_req = '0;
    unique case (ph)
      PH_ACQ: begin
        seq_req[DOM_ANA] = 1'b1;
        seq_req[DOM_DAC] = 1'b1;
      end
      PH_CONV: begin
        seq_req[DOM_CNV] = 1'b1;
        seq_req[DOM_DIG] = 1'b1;
      end
      PH_READ: seq_req[DOM_DIG] = 1'b1;
      default: seq_req = '0;
    endcase
  end

  assign clk_req = (ph == PH_CONV) || (ph == PH_READ);
endmodule

// File: rtl/pp_domain.sv
module pp_domain #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic force_on,
  input  logic force_off,
  output logic en,
  output logic rdy
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      cnt <= '0;
    end else begin
      en <= !force_off && (force_on || req);
      if (!en)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  assign rdy = en && (cnt == CNT_MAX);
endmodule

// File: rtl/pp_clk_gate.sv
module pp_clk_gate #(
  parameter bit SRC_IS_CLK = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic req,
  output logic gclk
);
  logic en_q;

  // Enable updated on the falling edge, and only while the source is low
  always_ff @(negedge clk) begin
    if (rst)
      en_q <= 1'b0;
    else if (SRC_IS_CLK || !src)
      en_q <= req;
  end

  assign gclk = src & en_q;
endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import pp_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int SLOW_DIV   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acq_start,
  input  logic             acq_stop,
  input  logic             conv_end,
  input  logic             ro_start,
  input  logic             ro_done,
  input  logic [N_DOM-1:0] cfg_force_on,
  input  logic [N_DOM-1:0] cfg_force_off,
  output logic [N_DOM-1:0] pwr_en,
  output logic [N_DOM-1:0] pwr_rdy,
  output logic             gclk_fast,
  output logic             gclk_slow,
  output logic             rx_fast_bias,
  output logic             rx_slow_bias,
  output logic             rx_trig_bias,
  output logic             ro_end
);
  localparam int HALF  = SLOW_DIV / 2;
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);

  logic [N_DOM-1:0] seq_req;
  logic             clk_req;
  logic             bias_q;
  logic [DIV_W-1:0] div_cnt;
  logic             slow_ph;

  pp_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .acq_start (acq_start),
    .acq_stop  (acq_stop),
    .conv_end  (conv_end),
    .ro_start  (ro_start),
    .ro_done   (ro_done),
    .seq_req   (seq_req),
    .clk_req   (clk_req),
    .ro_end    (ro_end)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    pp_domain #(.SETTLE_CYC(SETTLE_CYC)) u_dom (
      .clk       (clk),
      .rst       (rst),
      .req       (seq_req[d]),
      .force_on  (cfg_force_on[d]),
      .force_off (cfg_force_off[d]),
      .en        (pwr_en[d]),
      .rdy       (pwr_rdy[d])
    );
  end

  // Free-running divided clock source
  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      slow_ph <= 1'b0;
      bias_q  <= 1'b0;
    end else begin
      bias_q <= clk_req;
      if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        slow_ph <= !slow_ph;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  pp_clk_gate #(.SRC_IS_CLK(1'b1)) u_gate_fast (
    .clk  (clk),
    .rst  (rst),
    .src  (clk),
    .req  (bias_q),
    .gclk (gclk_fast)
  );

  pp_clk_gate #(.SRC_IS_CLK(1'b0)) u_gate_slow (
    .clk  (clk),
    .rst  (rst),
    .src  (slow_ph),
    .req  (bias_q),
    .gclk (gclk_slow)
  );

  assign rx_fast_bias = bias_q;
  assign rx_slow_bias = bias_q;
  assign rx_trig_bias = pwr_en[DOM_ANA];
endmodule

// File: rtl/pp_sequencer_chk.sv
module pp_sequencer_chk
  import pp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [N_DOM-1:0] cfg_force_on,
  input logic [N_DOM-1:0] cfg_force_off,
  input logic [N_DOM-1:0] pwr_en,
  input logic [N_DOM-1:0] pwr_rdy,
  input logic             ro_end,
  input logic             rx_fast_bias,
  input logic             gclk_slow,
  input logic             slow_ph
);
  for (genvar d = 0; d < N_DOM; d++) begin : g_a
    AST_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
      $past(cfg_force_off[d]) |-> !pwr_en[d]); // R4
    AST_FORCE_ON: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(cfg_force_on[d]) && !$past(cfg_force_off[d])) |-> pwr_en[d]); // R4
    AST_RDY_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
      pwr_rdy[d] |-> pwr_en[d]); // R7
    AST_RDY_SETTLED: assert property (@(posedge clk) disable iff (rst)
      $rose(pwr_rdy[d]) |-> $past(pwr_en[d])); // R7
  end

  AST_NO_ANA_DIG_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_force_on) == '0) |-> !(pwr_en[DOM_ANA] && pwr_en[DOM_DIG])); // R3
  AST_RO_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    ro_end |=> !ro_end); // R8
  AST_DIG_OFF_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    ($past(ro_end) && !$past(cfg_force_on[DOM_DIG])) |-> (!pwr_en[DOM_DIG] && !rx_fast_bias)); // R8
  AST_SLOW_RISE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $rose(gclk_slow) |-> $rose(slow_ph)); // R9
  AST_SLOW_FALL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(gclk_slow) |-> $fell(slow_ph)); // R9
endmodule

bind pp_sequencer pp_sequencer_chk u_chk (.*);

// File: tb/tb_pp_sequencer.sv
module tb_pp_sequencer;
  localparam int SETTLE = 4;
  localparam int SDIV   = 8;
  localparam int NV     = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acq_start = 0, acq_stop = 0, conv_end = 0, ro_start = 0, ro_done = 0;
  logic [3:0] cfg_force_on = '0, cfg_force_off = '0;
  logic [3:0] pwr_en, pwr_rdy;
  logic gclk_fast, gclk_slow, rx_fast_bias, rx_slow_bias, rx_trig_bias, ro_end;

  int n_chk = 0, n_fail = 0;
  int fast_edges = 0, slow_edges = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge gclk_fast) fast_edges++;
  always @(posedge gclk_slow) slow_edges++;

  pp_sequencer #(.SETTLE_CYC(SETTLE), .SLOW_DIV(SDIV)) dut (.*);

  // {ev[4:0] = ro_done,ro_start,conv_end,acq_stop,acq_start ; force_on ; force_off ;
  //  pwr {dig,dac,conv,ana} ; clock bias ; trigger bias}
  typedef logic [18:0] vec_t;
  localparam vec_t VECS [NV] = '{
    {5'b01000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R2 token in idle ignored
    {5'b00001, 4'b0000, 4'b0000, 4'b0101, 1'b0, 1'b1}, // R3 R6 acquire
    {5'b00100, 4'b0000, 4'b0000, 4'b0101, 1'b0, 1'b1}, // R2 conv_end in acquire ignored
    {5'b00010, 4'b0000, 4'b0000, 4'b1010, 1'b1, 1'b0}, // R3 R5 convert
    {5'b00100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R3 R5 wait
    {5'b10000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R2 ro_done in wait ignored
    {5'b01000, 4'b0000, 4'b0000, 4'b1000, 1'b1, 1'b0}, // R3 R5 readout
    {5'b10000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R2 back to idle
    {5'b00000, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b1}, // R4 R6 force analog on
    {5'b00000, 4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b0}, // R4 off wins
    {5'b00001, 4'b0010, 4'b0000, 4'b0111, 1'b0, 1'b1}, // R4 force conv + acquire
    {5'b00000, 4'b0000, 4'b0100, 4'b0001, 1'b0, 1'b1}, // R4 force DAC off
    {5'b00010, 4'b0000, 4'b0000, 4'b1010, 1'b1, 1'b0}, // R3 convert
    {5'b00000, 4'b0000, 4'b1000, 4'b0010, 1'b1, 1'b0}, // R5 bias ignores force
    {5'b00100, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}, // R3 wait
    {5'b01000, 4'b0000, 4'b0000, 4'b1000, 1'b1, 1'b0}, // R3 readout
    {5'b10000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0}  // R8 idle
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_events(input logic [4:0] ev);
    {ro_done, ro_start, conv_end, acq_stop, acq_start} = ev;
  endtask

  task automatic step(input logic [4:0] ev);
    @(negedge clk); set_events(ev);
    @(negedge clk); set_events(5'b0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {pwr_en, pwr_rdy, rx_fast_bias, rx_slow_bias, rx_trig_bias, ro_end},
          32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after release", {pwr_en, pwr_rdy, rx_fast_bias, rx_trig_bias, ro_end, gclk_slow},
          32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      cfg_force_on  = v[13:10];
      cfg_force_off = v[9:6];
      set_events(v[18:14]);
      @(negedge clk); set_events(5'b0);
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i),
            {pwr_en, rx_fast_bias, rx_slow_bias, rx_trig_bias},
            {v[5:2], v[1], v[1], v[0]});
    end

    // R7 settling: force DAC on in idle
    @(negedge clk); cfg_force_on = 4'b0100;
    repeat (SETTLE) @(negedge clk);
    check("R7 not ready before settle", {pwr_en[2], pwr_rdy[2]}, 2'b10);
    @(negedge clk);
    check("R7 ready after settle", {pwr_en[2], pwr_rdy[2]}, 2'b11);
    cfg_force_on = 4'b0000;
    @(negedge clk);
    check("R7 ready drops with enable", {pwr_en[2], pwr_rdy[2]}, 2'b00);

    // R9 gated clocks silent in idle
    repeat (10) @(negedge clk);
    fast_edges = 0; slow_edges = 0;
    repeat (64) @(negedge clk);
    check("R9 idle fast edges", fast_edges, 0);
    check("R9 idle slow edges", slow_edges, 0);

    // go to readout
    step(5'b00001); step(5'b00010); step(5'b00100); step(5'b01000);
    repeat (10) @(negedge clk);
    fast_edges = 0; slow_edges = 0;
    repeat (64) @(negedge clk);
    check("R9 readout fast edges", fast_edges, 64);
    check("R9 readout slow edges", slow_edges, 64 / SDIV);

    // R8 end-of-readout pulse and power-down
    @(negedge clk); ro_done = 1'b1;
    @(negedge clk); ro_done = 1'b0;
    check("R8 ro_end pulse", {ro_end, pwr_en[3]}, 2'b11);
    @(negedge clk);
    check("R8 pulse gone, digital off", {ro_end, pwr_en[3], rx_fast_bias}, 3'b000);

    // R2 late ro_done in idle has no effect
    step(5'b10000);
    check("R2 ro_done in idle ignored", {pwr_en, ro_end, rx_fast_bias}, 6'b0);

    // R1 reset mid-acquisition
    step(5'b00001);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset in acquire", {pwr_en, pwr_rdy, rx_trig_bias}, 9'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule